// File: doc/BRIEF.md
# Wrapping Burst Address and Byte-Mask Generator

This block sits between a 64-bit internal bus and a 32-bit memory data path. It accepts one transfer request at a time and expands it into a sequence of narrow memory beats, one per clock. Each beat carries a word address and a 4-bit byte mask. A request gives a start address, a burst/single flag and a byte count.

A burst covers one aligned 32-byte line as four 8-byte wide beats. The wide beat that holds the start address comes first. The following wide beats go up through the line and wrap back to its lowest beat. Each wide beat is sent as two narrow words, lower word first, and no byte is masked. A single transfer moves 1 to 8 contiguous bytes inside one aligned 8-byte range. It is sent as the two narrow words of that range, with the unwanted byte lanes masked. A done strobe on the second word tells the memory side that the useful data is complete, so that side can cut the access short. A single transfer whose bytes would leave the 8-byte range is rejected with a one-cycle error strobe and produces no beats.

Top module: `wrap_burst_gen`

## Requirements
- R1: After reset, reqReady is 1, and memValid, reqErr, memLast, singleDone and dataMask are all 0.
- R2: A burst is taken when reqValid and reqReady are both 1 at a clock edge. It then produces exactly 8 narrow beats on consecutive cycles, and the first beat appears in the cycle right after acceptance.
- R3: For a burst, wide beat i (i = 0..3) has index (reqAddr[4:3] + i) mod 4. Every beat keeps the upper address bits [ADDR_W-1:5] of the request, so the sequence wraps within the aligned 32-byte line.
- R4: Each wide beat is sent as two narrow beats. The first has memAddr[2] = 0 and the second has memAddr[2] = 1, and memAddr[1:0] is always 0.
- R5: During a burst, dataMask is 0 on every beat. reqAddr[2:0] and reqSize have no effect on the beats of a burst.
- R6: A legal single transfer produces exactly two narrow beats, starting the cycle after acceptance. Their addresses are the request address with bits [2:0] cleared, then the same address plus 4.
- R7: Byte lanes are numbered so that lane 0 is the lowest address of the memory word, and the mask is active high (1 masks the lane). On narrow beat h of a single transfer (h = 0 lower word, h = 1 upper word), dataMask bit k is 1 exactly when byte position 4*h + k lies outside [reqAddr[2:0], reqAddr[2:0] + reqSize). dataMask is 0 whenever memValid is 0.
- R8: memLast is 1 only on the final beat of a transfer. singleDone is 1 only on the second beat of a single transfer, and never during a burst.
- R9: A single request with reqSize = 0, reqSize > 8, or reqAddr[2:0] + reqSize > 8 is accepted without producing any beat. reqErr is 1 for exactly the one cycle after acceptance, and reqReady stays 1.
- R10: reqReady is 0 while beats of an accepted transfer are still to come. It returns to 1 in the cycle after the final beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request |
| reqAddr | input | ADDR_W | Byte start address |
| reqBurst | input | 1 | 1 selects a wrapping 32-byte burst, 0 a single transfer |
| reqSize | input | 4 | Byte count of a single transfer (1..8), ignored for bursts |
| reqErr | output | 1 | One-cycle strobe for a rejected single request |
| memValid | output | 1 | A narrow memory beat is presented |
| memAddr | output | ADDR_W | Byte address of the current 32-bit word |
| dataMask | output | 4 | Per-lane mask, 1 masks the byte, lane 0 lowest address |
| memLast | output | 1 | Final beat of the transfer |
| singleDone | output | 1 | Useful data of a single transfer complete |

## Verification
On every cycle, the assertions check the handshake and framing rules. Beats never overlap a ready request. Once a beat sequence starts, it continues without gaps until memLast, and ready comes back right after it. Narrow words alternate lower then upper, stay word aligned, stay in one line, and step the wide index by one modulo 4. The error strobe only follows an acceptance and never comes with a beat. The exact wrap order for each start beat, the mask pattern for every offset and size, and the fact that burst beats do not depend on the low address bits and the size can only be shown by the bench. It runs an exhaustive sweep against expected beats computed from the rules.

// File: rtl/bmg_pkg.sv
package bmg_pkg;
  localparam int LANES      = 4;
  localparam int WIDE_BYTES = 8;
  localparam int BURST_WIDE = 4;

  localparam int LANE_W     = $clog2(LANES);
  localparam int OFF_W      = $clog2(WIDE_BYTES);
  localparam int BIDX_W     = $clog2(BURST_WIDE);
  localparam int LINE_LSB   = OFF_W + BIDX_W;
  localparam int HALVES     = WIDE_BYTES / LANES;
  localparam int HALF_W     = $clog2(HALVES);
  localparam int NARROW_MAX = BURST_WIDE * HALVES;
  localparam int CNT_W      = $clog2(NARROW_MAX);
  localparam int SIZE_W     = OFF_W + 1;

  typedef struct packed {
    logic load;
    logic beat;
    logic last;
  } ctrlStrb_t;
endpackage

// File: rtl/bmg_ctrl.sv
module bmg_ctrl
  import bmg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqBurst,
  input  logic             reqLegal,
  output logic             reqReady,
  output logic             errPulse,
  output ctrlStrb_t        strb,
  output logic [CNT_W-1:0] beatCnt
);
  logic             busy;
  logic [CNT_W-1:0] lastIdx;
  logic             accept;
  logic             atLast;

  assign accept = reqValid && !busy;
  assign atLast = (beatCnt == lastIdx);

  always_comb begin
    strb.load = accept && reqLegal;
    strb.beat = busy;
    strb.last = busy && atLast;
  end

  assign reqReady = !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      beatCnt  <= '0;
      lastIdx  <= '0;
      errPulse <= 1'b0;
    end else begin
      errPulse <= accept && !reqLegal;
      if (strb.load) begin
        busy    <= 1'b1;
        beatCnt <= '0;
        lastIdx <= reqBurst ? CNT_W'(NARROW_MAX - 1) : CNT_W'(HALVES - 1);
      end else if (busy) begin
        if (atLast) busy <= 1'b0;
        else        beatCnt <= beatCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bmg_datapath.sv
module bmg_datapath
  import bmg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqBurst,
  input  logic [SIZE_W-1:0] reqSize,
  input  ctrlStrb_t         strb,
  input  logic [CNT_W-1:0]  beatCnt,
  output logic              reqLegal,
  output logic              memValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  dataMask,
  output logic              memLast,
  output logic              singleDone
);
  logic [ADDR_W-1:LINE_LSB] lineQ;
  logic [BIDX_W-1:0]        startQ;
  logic [OFF_W-1:0]         offQ;
  logic [SIZE_W-1:0]        sizeQ;
  logic                     burstQ;

  logic [SIZE_W:0]          reqEnd;
  logic [SIZE_W:0]          endQ;
  logic [BIDX_W-1:0]        wideIdx;
  logic [HALF_W-1:0]        half;

  assign reqEnd   = (SIZE_W+1)'(reqAddr[OFF_W-1:0]) + (SIZE_W+1)'(reqSize);
  assign reqLegal = reqBurst || ((reqSize != '0) && (reqEnd <= (SIZE_W+1)'(WIDE_BYTES)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineQ  <= '0;
      startQ <= '0;
      offQ   <= '0;
      sizeQ  <= '0;
      burstQ <= 1'b0;
    end else if (strb.load) begin
      lineQ  <= reqAddr[ADDR_W-1:LINE_LSB];
      startQ <= reqAddr[LINE_LSB-1:OFF_W];
      offQ   <= reqAddr[OFF_W-1:0];
      sizeQ  <= reqSize;
      burstQ <= reqBurst;
    end
  end

  assign half    = beatCnt[HALF_W-1:0];
  assign wideIdx = burstQ ? startQ + beatCnt[CNT_W-1:HALF_W] : startQ;
  assign memAddr = {lineQ, wideIdx, half, LANE_W'(0)};
  assign endQ    = (SIZE_W+1)'(offQ) + (SIZE_W+1)'(sizeQ);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [OFF_W-1:0] bytePos;
    logic             inRange;
    assign bytePos     = {half, LANE_W'(l)};
    assign inRange     = (bytePos >= offQ) && ((SIZE_W+1)'(bytePos) < endQ);
    assign dataMask[l] = strb.beat && !burstQ && !inRange;
  end

  assign memValid   = strb.beat;
  assign memLast    = strb.last;
  assign singleDone = strb.last && !burstQ;
endmodule

// File: rtl/wrap_burst_gen.sv
module wrap_burst_gen
  import bmg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqBurst,
  input  logic [SIZE_W-1:0] reqSize,
  output logic              reqErr,
  output logic              memValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  dataMask,
  output logic              memLast,
  output logic              singleDone
);
  ctrlStrb_t        strb;
  logic [CNT_W-1:0] beatCnt;
  logic             reqLegal;

  bmg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqBurst (reqBurst),
    .reqLegal (reqLegal),
    .reqReady (reqReady),
    .errPulse (reqErr),
    .strb     (strb),
    .beatCnt  (beatCnt)
  );

  bmg_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .reqAddr    (reqAddr),
    .reqBurst   (reqBurst),
    .reqSize    (reqSize),
    .strb       (strb),
    .beatCnt    (beatCnt),
    .reqLegal   (reqLegal),
    .memValid   (memValid),
    .memAddr    (memAddr),
    .dataMask   (dataMask),
    .memLast    (memLast),
    .singleDone (singleDone)
  );
endmodule

// File: rtl/bmg_checker.sv
module bmg_checker
  import bmg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqErr,
  input logic              memValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic [LANES-1:0]  dataMask,
  input logic              memLast,
  input logic              singleDone
);
  p_first_beat_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (memValid || reqErr));

  p_no_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memLast) |=> memValid);

  p_same_line_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memLast) |=> (memAddr[ADDR_W-1:LINE_LSB] == $past(memAddr[ADDR_W-1:LINE_LSB])));

  p_wrap_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memLast && memAddr[LANE_W]) |=>
      (memAddr[LINE_LSB-1:OFF_W] == $past(memAddr[LINE_LSB-1:OFF_W]) + 1'b1));

  p_word_alternate_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memLast) |=> (memAddr[LANE_W] == !$past(memAddr[LANE_W])));

  p_word_aligned_r4: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> (memAddr[LANE_W-1:0] == '0));

  p_mask_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !memValid |-> (dataMask == '0));

  p_done_on_last_r8: assert property (@(posedge clk) disable iff (!rstN)
    singleDone |-> (memValid && memLast && memAddr[LANE_W]));

  p_err_no_beat_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqErr |-> (!memValid && reqReady));

  p_err_after_accept_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqErr |-> $past(reqValid && reqReady));

  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> !reqReady);

  p_ready_after_last_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memLast) |=> reqReady);
endmodule

bind wrap_burst_gen bmg_checker #(.ADDR_W(ADDR_W)) u_bmg_checker (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .reqErr     (reqErr),
  .memValid   (memValid),
  .memAddr    (memAddr),
  .dataMask   (dataMask),
  .memLast    (memLast),
  .singleDone (singleDone)
);

// File: tb/test_wrap_burst_gen.sv
`timescale 1ns/1ps
module test_wrap_burst_gen;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rstN;
  logic          reqValid;
  logic          reqReady;
  logic [AW-1:0] reqAddr;
  logic          reqBurst;
  logic [3:0]    reqSize;
  logic          reqErr;
  logic          memValid;
  logic [AW-1:0] memAddr;
  logic [3:0]    dataMask;
  logic          memLast;
  logic          singleDone;

  always #2.5 clk = ~clk;

  wrap_burst_gen #(.ADDR_W(AW)) i_wrap_burst_gen (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqBurst(reqBurst), .reqSize(reqSize), .reqErr(reqErr),
    .memValid(memValid), .memAddr(memAddr), .dataMask(dataMask),
    .memLast(memLast), .singleDone(singleDone)
  );

  typedef struct {
    logic [AW-1:0] addr;
    logic [3:0]    mask;
    logic          last;
    logic          done;
    logic          isBurst;
  } beat_t;

  beat_t expQ[$];
  int    errPending = 0;
  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  // Scoreboard monitor: compares every presented beat with the queue head.
  always @(negedge clk) begin
    if (rstN === 1'b1 && !finished) begin
      if (memValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, $sformatf("R2 unexpected beat addr=%h expected none", memAddr));
        end else begin
          beat_t e;
          e = expQ.pop_front();
          check(memAddr == e.addr, $sformatf("%s addr actual=%h expected=%h",
                e.isBurst ? "R3" : "R6", memAddr, e.addr));
          check(dataMask == e.mask, $sformatf("%s mask actual=%b expected=%b",
                e.isBurst ? "R5" : "R7", dataMask, e.mask));
          check(memLast == e.last && singleDone == e.done,
                $sformatf("R8 last/done actual=%b%b expected=%b%b",
                memLast, singleDone, e.last, e.done));
        end
      end
      if (reqErr) begin
        check(errPending > 0, $sformatf("R9 error strobe actual=1 expected=0"));
        check(!memValid, $sformatf("R9 beat with error actual=%b expected=0", memValid));
        if (errPending > 0) errPending--;
      end
    end
  end

  task automatic send(input logic [AW-1:0] a, input bit burst, input logic [3:0] sz);
    int  nBeats;
    bit  legal;
    int  off;
    off   = int'(a[2:0]);
    legal = burst || (sz != 0 && off + int'(sz) <= 8);
    nBeats = burst ? 8 : (legal ? 2 : 0);
    while (reqReady !== 1'b1) @(negedge clk);
    if (burst) begin
      for (int i = 0; i < 4; i++) begin
        for (int h = 0; h < 2; h++) begin
          beat_t e;
          e.addr    = {a[AW-1:5], 5'b0} + AW'(((int'(a[4:3]) + i) % 4) * 8 + h * 4);
          e.mask    = 4'b0000;
          e.last    = (i == 3 && h == 1);
          e.done    = 1'b0;
          e.isBurst = 1'b1;
          expQ.push_back(e);
        end
      end
    end else if (legal) begin
      for (int h = 0; h < 2; h++) begin
        beat_t e;
        e.addr = {a[AW-1:3], 3'b0} + AW'(h * 4);
        for (int k = 0; k < 4; k++) begin
          int p;
          p = h * 4 + k;
          e.mask[k] = !(p >= off && p < off + int'(sz));
        end
        e.last    = (h == 1);
        e.done    = (h == 1);
        e.isBurst = 1'b0;
        expQ.push_back(e);
      end
    end else begin
      errPending++;
    end
    reqAddr  = a;
    reqBurst = burst;
    reqSize  = sz;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    reqAddr  = ~a;
    reqSize  = ~sz;
    if (legal) begin
      check(reqReady == 1'b0, $sformatf("R10 ready during transfer actual=%b expected=0", reqReady));
      repeat (nBeats - 1) @(negedge clk);
      check(memLast == 1'b1, $sformatf("R2 final beat timing actual=%b expected=1", memLast));
      @(negedge clk);
      check(reqReady == 1'b1, $sformatf("R10 ready after last actual=%b expected=1", reqReady));
      check(memValid == 1'b0, $sformatf("R2 beat count overrun actual=%b expected=0", memValid));
    end else begin
      check(reqReady == 1'b1, $sformatf("R9 ready on reject actual=%b expected=1", reqReady));
      @(negedge clk);
      check(reqErr == 1'b0, $sformatf("R9 error width actual=%b expected=0", reqErr));
    end
  endtask

  initial begin
    rstN     = 1'b0;
    reqValid = 1'b0;
    reqAddr  = '0;
    reqBurst = 1'b0;
    reqSize  = '0;
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1 && memValid == 1'b0 && reqErr == 1'b0 &&
          memLast == 1'b0 && singleDone == 1'b0 && dataMask == 4'b0,
          $sformatf("R1 reset state rdy=%b val=%b err=%b expected 1 0 0",
          reqReady, memValid, reqErr));
    rstN = 1'b1;
    @(negedge clk);

    // R3 R5: every start beat and every low offset, size varied to show it is ignored
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 8; o++)
        send(32'h1234_5600 + AW'(s * 8 + o), 1'b1, 4'(o * 3 + s));
    send(32'hFFFF_FFF9, 1'b1, 4'd0);

    // R6 R7: exhaustive offsets and sizes, including the R9 illegal ones
    for (int o = 0; o < 8; o++)
      for (int z = 0; z < 16; z++)
        send(32'h0000_A0C0 + AW'(o), 1'b0, 4'(z));

    // R9 then immediate R6 request, and single in the upper half of a line
    send(32'h0000_0007, 1'b0, 4'd2);
    send(32'h0000_0018, 1'b0, 4'd8);
    send(32'h0000_001D, 1'b0, 4'd3);
    send(32'h0000_0010, 1'b1, 4'd1);

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, $sformatf("R2 beats missing actual=%0d expected=0", expQ.size()));
    check(errPending == 0, $sformatf("R9 error strobes missing actual=%0d expected=0", errPending));
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule